// File: doc/BRIEF.md
# NAND Flash Single-Operation Launch Sequencer

This block drives an 8-bit NAND flash bus one elementary operation at a time. Software fills a command register, an address register and a buffer-area select register through a 16-bit register port. It then writes a one-hot launch code into the control register. The sequencer runs exactly one bus primitive: a command latch, an address latch, a page transfer from buffer to flash, a page transfer from flash to buffer, an ID read or a status read. When the primitive ends it raises a sticky completion flag, and software polls that flag.

Page data moves through an internal byte buffer split into areas. Each area holds one page plus its spare bytes. Software reads and writes the buffer through a separate byte port. The flash ready/busy line is an input. A flash-to-buffer transfer waits for that line to be high before its first read strobe. Each strobe has three phases, setup, active-low pulse and hold, and each phase lasts a parameterised number of cycles.

Top module: `nand_launch_seq`

## Requirements
- R1: After reset the control register reads 0, CLE and ALE are low, the write and read strobes are high and the data bus is not driven.
- R2: Writing control value 0x0001 produces one write-strobe pulse with CLE high and ALE low; the bus carries bits [7:0] of the command register (register index 0) at the rising edge of the strobe.
- R3: Writing control value 0x0002 produces one write-strobe pulse with ALE high and CLE low; the bus carries bits [7:0] of the address register (register index 1), unshifted.
- R4: Writing control value 0x0004 produces PAGE_BYTES+SPARE_BYTES write-strobe pulses with CLE and ALE low. The pulses carry the bytes of the area chosen by register index 2, in order from offset 0.
- R5: Writing control value 0x0008 makes no read strobe while ready/busy is low. Once ready/busy is high, the block makes PAGE_BYTES+SPARE_BYTES read strobes and stores the bytes at offsets 0 upward of the selected area. Buffer byte address = area * (PAGE_BYTES+SPARE_BYTES) + offset.
- R6: Writing control value 0x0010 produces ID_BYTES read strobes and stores the bytes at offsets 0 upward of the selected area; later bytes of the area are left unchanged.
- R7: Writing control value 0x0020 produces exactly one read strobe and stores the status byte at offset 0 of the selected area; the other bytes are left unchanged.
- R8: Control bit 15 is set when an operation ends and stays set. A control write with bit 15 = 1 leaves it set; a control write with bit 15 = 0 clears it.
- R9: A control write that arrives while an operation runs is ignored: the running operation continues, readback bits [5:0] still show its one-hot code, and no extra strobe appears.
- R10: A control write whose bits [5:0] are not one-hot (zero or more than one bit set) starts no operation and sets no flag.
- R11: Every strobe stays low for exactly PULSE_CYC clock cycles. Consecutive strobes of one operation are separated by at least SETUP_CYC+HOLD_CYC cycles high, and the bus stays stable while a write strobe is low.
- R12: CLE and ALE are never high together, and the write and read strobes are never low together.
- R13: Register indices 0, 1 and 2 read back the last 16-bit value written. Index 3 reads {done flag, 9 zero bits, one-hot code of the running operation or 0 when idle}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write enable |
| regAddr | input | 2 | Register index: 0 command, 1 address, 2 area select, 3 control |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data for regAddr (combinational) |
| bufWe | input | 1 | Buffer byte write enable |
| bufAddr | input | BUF_AW | Buffer byte address |
| bufWdata | input | 8 | Buffer write byte |
| bufRdata | output | 8 | Buffer byte at bufAddr (combinational) |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandDout | output | 8 | Bus data toward flash |
| nandDoe | output | 1 | Bus output enable |
| nandDin | input | 8 | Bus data from flash |
| nandRb | input | 1 | Ready/busy, high when ready |

## Verification
The bench holds ready/busy low after launching a page read and checks that no read strobe appears. A design that ignored the line would fill the buffer from a busy device. It launches a second operation during a long page write; a design that accepted it would mix a command latch into the page or change the reported operation code. It writes a launch code with two bits set, which a priority decoder would wrongly accept as one operation. It checks that writing 1 to the done bit keeps the flag, which catches a flag that clears on any write. A bus model in the bench times every strobe, catching off-by-one phase counters.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    SRC_CMD  = 2'd0,
    SRC_ADDR = 2'd1,
    SRC_BUF  = 2'd2
  } srcSel_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WAITRB = 3'd1,
    ST_SETUP  = 3'd2,
    ST_PULSE  = 3'd3,
    ST_HOLD   = 3'd4
  } seqState_e;

  // one-hot launch code bit positions (software visible)
  localparam int OP_W    = 6;
  localparam int OP_CMD  = 0;
  localparam int OP_ADDR = 1;
  localparam int OP_WPG  = 2;
  localparam int OP_RPG  = 3;
  localparam int OP_ID   = 4;
  localparam int OP_STAT = 5;

  typedef struct packed {
    logic    cle;
    logic    ale;
    logic    weLow;
    logic    reLow;
    logic    drive;
    srcSel_e src;
    logic    capture;
    logic    ptrClr;
    logic    ptrInc;
  } strobe_t;

endpackage

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int PULSE_CYC  = 2,
  parameter int HOLD_CYC   = 1,
  parameter int AREA_BYTES = 20,
  parameter int ID_BYTES   = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ctlWe,
  input  logic            ctlDoneBit,
  input  logic [OP_W-1:0] ctlLaunch,
  input  logic            nandRb,
  output strobe_t         stb,
  output logic            opDone,
  output logic [OP_W-1:0] curOp
);

  localparam int MAX_PH = (SETUP_CYC > PULSE_CYC) ?
                          ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                          ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
  localparam int CNT_W = $clog2(MAX_PH + 1);
  localparam int IDX_W = $clog2(AREA_BYTES + 1);

  seqState_e        state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] lastIdx;
  logic             launchOk;
  logic             isWrite;
  logic             isRead;
  logic             inStrobe;

  assign launchOk = ctlWe && (state == ST_IDLE) && ($countones(ctlLaunch) == 1);
  assign isWrite  = curOp[OP_CMD] | curOp[OP_ADDR] | curOp[OP_WPG];
  assign isRead   = curOp[OP_RPG] | curOp[OP_ID] | curOp[OP_STAT];
  assign inStrobe = (state == ST_SETUP) || (state == ST_PULSE) || (state == ST_HOLD);

  always_comb begin
    if (curOp[OP_WPG] || curOp[OP_RPG]) lastIdx = IDX_W'(AREA_BYTES - 1);
    else if (curOp[OP_ID])              lastIdx = IDX_W'(ID_BYTES - 1);
    else                                lastIdx = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      idx    <= '0;
      curOp  <= '0;
      opDone <= 1'b0;
    end else begin
      if (ctlWe) opDone <= opDone & ctlDoneBit;
      unique case (state)
        ST_IDLE: begin
          if (launchOk) begin
            curOp <= ctlLaunch;
            idx   <= '0;
            cnt   <= '0;
            state <= ctlLaunch[OP_RPG] ? ST_WAITRB : ST_SETUP;
          end
        end
        ST_WAITRB: if (nandRb) state <= ST_SETUP;
        ST_SETUP: begin
          if (cnt == CNT_W'(SETUP_CYC - 1)) begin
            cnt   <= '0;
            state <= ST_PULSE;
          end else cnt <= cnt + 1'b1;
        end
        ST_PULSE: begin
          if (cnt == CNT_W'(PULSE_CYC - 1)) begin
            cnt   <= '0;
            state <= ST_HOLD;
          end else cnt <= cnt + 1'b1;
        end
        ST_HOLD: begin
          if (cnt == CNT_W'(HOLD_CYC - 1)) begin
            cnt <= '0;
            if (idx == lastIdx) begin
              state  <= ST_IDLE;
              curOp  <= '0;
              opDone <= 1'b1;
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_SETUP;
            end
          end else cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb         = '0;
    stb.src     = curOp[OP_CMD] ? SRC_CMD : (curOp[OP_ADDR] ? SRC_ADDR : SRC_BUF);
    stb.ptrClr  = launchOk;
    if (inStrobe) begin
      stb.cle     = curOp[OP_CMD];
      stb.ale     = curOp[OP_ADDR];
      stb.drive   = isWrite;
      stb.weLow   = isWrite && (state == ST_PULSE);
      stb.reLow   = isRead && (state == ST_PULSE);
      stb.capture = isRead && (state == ST_HOLD) && (cnt == '0);
      stb.ptrInc  = (state == ST_HOLD) && (cnt == CNT_W'(HOLD_CYC - 1));
    end
  end

  // R9: a write to the control register mid-operation leaves the running code alone
  assert_busy_launch_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWe && (state == ST_SETUP || state == ST_PULSE || state == ST_WAITRB)) |=> $stable(curOp));

  // R10: the running code is never a multi-bit value
  assert_single_op_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(curOp));

  // R5: while the device is busy the page read does not advance
  assert_wait_for_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAITRB && !nandRb) |=> (state == ST_WAITRB));

  // R8: the flag only rises at the end of a hold phase
  assert_done_on_finish_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(opDone) |-> $past(state == ST_HOLD));

endmodule

// File: rtl/nand_seq_dpath.sv
module nand_seq_dpath
  import nand_seq_pkg::*;
#(
  parameter int AREA_BYTES = 20,
  parameter int AREAS      = 2,
  parameter int BUF_AW     = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [15:0]       regWdata,
  output logic [15:0]       regRdata,
  input  logic              bufWe,
  input  logic [BUF_AW-1:0] bufAddr,
  input  logic [7:0]        bufWdata,
  output logic [7:0]        bufRdata,
  input  strobe_t           stb,
  input  logic              opDone,
  input  logic [OP_W-1:0]   curOp,
  input  logic [7:0]        nandDin,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic [7:0]        nandDout,
  output logic              nandDoe
);

  localparam int DEPTH = AREA_BYTES * AREAS;
  localparam int SEL_W = (AREAS > 1) ? $clog2(AREAS) : 1;
  localparam int PTR_W = $clog2(AREA_BYTES + 1);

  logic [15:0]       cmdReg;
  logic [15:0]       addrReg;
  logic [15:0]       selReg;
  logic [PTR_W-1:0]  ptr;
  logic [BUF_AW-1:0] seqIdx;
  logic [7:0]        busNext;
  logic [7:0]        mem [DEPTH];

  assign seqIdx = BUF_AW'(selReg[SEL_W-1:0]) * BUF_AW'(AREA_BYTES) + BUF_AW'(ptr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg  <= '0;
      addrReg <= '0;
      selReg  <= '0;
    end else if (regWe) begin
      case (regAddr)
        2'd0:    cmdReg  <= regWdata;
        2'd1:    addrReg <= regWdata;
        2'd2:    selReg  <= regWdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (regAddr)
      2'd0:    regRdata = cmdReg;
      2'd1:    regRdata = addrReg;
      2'd2:    regRdata = selReg;
      default: regRdata = {opDone, 9'd0, curOp};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           ptr <= '0;
    else if (stb.ptrClr) ptr <= '0;
    else if (stb.ptrInc) ptr <= ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (stb.capture)  mem[seqIdx]  <= nandDin;
    else if (bufWe)   mem[bufAddr] <= bufWdata;
  end

  assign bufRdata = mem[bufAddr];

  always_comb begin
    case (stb.src)
      SRC_CMD:  busNext = cmdReg[7:0];
      SRC_ADDR: busNext = addrReg[7:0];
      default:  busNext = mem[seqIdx];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nandCle  <= 1'b0;
      nandAle  <= 1'b0;
      nandWeN  <= 1'b1;
      nandReN  <= 1'b1;
      nandDoe  <= 1'b0;
      nandDout <= '0;
    end else begin
      nandCle <= stb.cle;
      nandAle <= stb.ale;
      nandWeN <= !stb.weLow;
      nandReN <= !stb.reLow;
      nandDoe <= stb.drive;
      if (stb.drive) nandDout <= busNext;
    end
  end

  assert_cle_ale_excl_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));

  assert_we_re_excl_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN));

  assert_bus_stable_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!nandWeN && $past(!nandWeN)) |-> $stable(nandDout));

  assert_drive_on_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    !nandWeN |-> nandDoe);

endmodule

// File: rtl/nand_launch_seq.sv
module nand_launch_seq
  import nand_seq_pkg::*;
#(
  parameter int PAGE_BYTES  = 16,
  parameter int SPARE_BYTES = 4,
  parameter int AREAS       = 2,
  parameter int ID_BYTES    = 4,
  parameter int SETUP_CYC   = 2,
  parameter int PULSE_CYC   = 2,
  parameter int HOLD_CYC    = 1,
  parameter int BUF_AW      = $clog2((PAGE_BYTES + SPARE_BYTES) * AREAS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [15:0]       regWdata,
  output logic [15:0]       regRdata,
  input  logic              bufWe,
  input  logic [BUF_AW-1:0] bufAddr,
  input  logic [7:0]        bufWdata,
  output logic [7:0]        bufRdata,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic [7:0]        nandDout,
  output logic              nandDoe,
  input  logic [7:0]        nandDin,
  input  logic              nandRb
);

  localparam int AREA_BYTES = PAGE_BYTES + SPARE_BYTES;

  strobe_t         stb;
  logic            opDone;
  logic [OP_W-1:0] curOp;
  logic            ctlWe;

  assign ctlWe = regWe && (regAddr == 2'd3);

  nand_seq_ctrl #(
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .AREA_BYTES(AREA_BYTES),
    .ID_BYTES  (ID_BYTES)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ctlWe     (ctlWe),
    .ctlDoneBit(regWdata[15]),
    .ctlLaunch (regWdata[OP_W-1:0]),
    .nandRb    (nandRb),
    .stb       (stb),
    .opDone    (opDone),
    .curOp     (curOp)
  );

  nand_seq_dpath #(
    .AREA_BYTES(AREA_BYTES),
    .AREAS     (AREAS),
    .BUF_AW    (BUF_AW)
  ) i_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .regWe   (regWe),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .bufWe   (bufWe),
    .bufAddr (bufAddr),
    .bufWdata(bufWdata),
    .bufRdata(bufRdata),
    .stb     (stb),
    .opDone  (opDone),
    .curOp   (curOp),
    .nandDin (nandDin),
    .nandCle (nandCle),
    .nandAle (nandAle),
    .nandWeN (nandWeN),
    .nandReN (nandReN),
    .nandDout(nandDout),
    .nandDoe (nandDoe)
  );

endmodule

// File: tb/test_nand_launch_seq.sv
`timescale 1ns/1ps
module test_nand_launch_seq;

  localparam int PAGE_BYTES = 16;
  localparam int SPARE_BYTES = 4;
  localparam int AREA = PAGE_BYTES + SPARE_BYTES;
  localparam int ID_BYTES = 4;
  localparam int SETUP_CYC = 2;
  localparam int PULSE_CYC = 2;
  localparam int HOLD_CYC = 1;
  localparam int BUF_AW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [1:0] regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic bufWe = 1'b0;
  logic [BUF_AW-1:0] bufAddr = '0;
  logic [7:0] bufWdata = '0;
  logic [7:0] bufRdata;
  logic nandCle, nandAle, nandWeN, nandReN, nandDoe;
  logic [7:0] nandDout;
  logic [7:0] nandDin = '0;
  logic nandRb = 1'b1;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  nand_launch_seq #(
    .PAGE_BYTES(PAGE_BYTES), .SPARE_BYTES(SPARE_BYTES), .AREAS(2), .ID_BYTES(ID_BYTES),
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC), .BUF_AW(BUF_AW)
  ) i_nand_launch_seq (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .bufWe(bufWe), .bufAddr(bufAddr), .bufWdata(bufWdata),
    .bufRdata(bufRdata), .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN),
    .nandReN(nandReN), .nandDout(nandDout), .nandDoe(nandDoe), .nandDin(nandDin),
    .nandRb(nandRb)
  );

  // flash bus model: logs write strobes, feeds read strobes, times every pulse
  logic [7:0] wrData [0:511];
  logic       wrCle  [0:511];
  logic       wrAle  [0:511];
  logic [7:0] rdData [0:511];
  int wrCount = 0;
  int rdCount = 0;
  int timingErr = 0;
  time fallT = 0;
  time lastRise = 0;

  always @(negedge nandWeN) if (rstN) begin
    if (lastRise != 0 && ($time - lastRise) < (SETUP_CYC + HOLD_CYC) * 4) timingErr++;
    fallT = $time;
  end
  always @(posedge nandWeN) if (rstN) begin
    if (($time - fallT) != PULSE_CYC * 4) timingErr++;
    wrData[wrCount] = nandDout;
    wrCle[wrCount] = nandCle;
    wrAle[wrCount] = nandAle;
    wrCount++;
    lastRise = $time;
  end
  always @(negedge nandReN) if (rstN) begin
    if (lastRise != 0 && ($time - lastRise) < (SETUP_CYC + HOLD_CYC) * 4) timingErr++;
    fallT = $time;
    nandDin = rdData[rdCount];
    rdCount++;
  end
  always @(posedge nandReN) if (rstN) begin
    if (($time - fallT) != PULSE_CYC * 4) timingErr++;
    lastRise = $time;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic bufWrite(input int a, input logic [7:0] d);
    @(negedge clk);
    bufAddr = BUF_AW'(a); bufWdata = d; bufWe = 1'b1;
    @(negedge clk);
    bufWe = 1'b0;
  endtask

  task automatic bufRead(input int a, output logic [7:0] d);
    @(negedge clk);
    bufAddr = BUF_AW'(a);
    #1 d = bufRdata;
  endtask

  task automatic waitDone(input string req);
    logic [15:0] v;
    bit seen = 0;
    for (int n = 0; n < 3000 && !seen; n++) begin
      regRead(2'd3, v);
      if (v[15]) seen = 1;
    end
    check(seen, req, 0, 1);
  endtask

  task automatic clearDone();
    regWrite(2'd3, 16'h0000);
  endtask

  task automatic test_reset();
    logic [15:0] v;
    regRead(2'd3, v);
    check(v == 16'h0000, "R1 control", v, 0);
    check(nandCle == 0 && nandAle == 0, "R1 latches", {nandCle, nandAle}, 0);
    check(nandWeN == 1 && nandReN == 1 && nandDoe == 0, "R1 strobes", {nandWeN, nandReN, nandDoe}, 3'b110);
  endtask

  task automatic test_regs();
    logic [15:0] v;
    regWrite(2'd0, 16'h12A5); regRead(2'd0, v); check(v == 16'h12A5, "R13 cmd", v, 16'h12A5);
    regWrite(2'd1, 16'h3C4D); regRead(2'd1, v); check(v == 16'h3C4D, "R13 addr", v, 16'h3C4D);
    regWrite(2'd2, 16'h0000); regRead(2'd2, v); check(v == 16'h0000, "R13 sel", v, 0);
  endtask

  task automatic test_cmd();
    logic [15:0] v;
    int base = wrCount;
    regWrite(2'd3, 16'h0001);
    waitDone("R2 done");
    check(wrCount - base == 1, "R2 count", wrCount - base, 1);
    check(wrCle[base] == 1 && wrAle[base] == 0, "R2 cle", {wrCle[base], wrAle[base]}, 2'b10);
    check(wrData[base] == 8'hA5, "R2 data", wrData[base], 8'hA5);
    repeat (10) @(negedge clk);
    regRead(2'd3, v); check(v == 16'h8000, "R8 sticky", v, 16'h8000);
    regWrite(2'd3, 16'h8000);
    regRead(2'd3, v); check(v[15] == 1, "R8 write one keeps", v, 16'h8000);
    clearDone();
    regRead(2'd3, v); check(v == 16'h0000, "R8 clear", v, 0);
  endtask

  task automatic test_addr();
    int base = wrCount;
    regWrite(2'd3, 16'h0002);
    waitDone("R3 done");
    check(wrCount - base == 1, "R3 count", wrCount - base, 1);
    check(wrCle[base] == 0 && wrAle[base] == 1, "R3 ale", {wrCle[base], wrAle[base]}, 2'b01);
    check(wrData[base] == 8'h4D, "R3 data", wrData[base], 8'h4D);
    clearDone();
  endtask

  task automatic test_page_write(input int area);
    int base;
    int bad = 0;
    int latchBad = 0;
    regWrite(2'd2, 16'(area));
    for (int i = 0; i < AREA; i++) bufWrite(area * AREA + i, 8'(i * 7 + 3 + area * 64));
    base = wrCount;
    regWrite(2'd3, 16'h0004);
    waitDone("R4 done");
    check(wrCount - base == AREA, "R4 count", wrCount - base, AREA);
    for (int i = 0; i < AREA; i++) begin
      if (wrData[base + i] != 8'(i * 7 + 3 + area * 64)) bad++;
      if (wrCle[base + i] || wrAle[base + i]) latchBad++;
    end
    check(bad == 0, "R4 data", bad, 0);
    check(latchBad == 0, "R4 latches low", latchBad, 0);
    clearDone();
  endtask

  task automatic test_page_read();
    logic [7:0] b;
    int base = rdCount;
    int bad = 0;
    regWrite(2'd2, 16'h0000);
    for (int i = 0; i < AREA; i++) rdData[base + i] = 8'hC0 ^ 8'(i * 3);
    nandRb = 1'b0;
    regWrite(2'd3, 16'h0008);
    repeat (40) @(negedge clk);
    check(rdCount == base, "R5 waits busy", rdCount - base, 0);
    nandRb = 1'b1;
    waitDone("R5 done");
    check(rdCount - base == AREA, "R5 count", rdCount - base, AREA);
    for (int i = 0; i < AREA; i++) begin
      bufRead(i, b);
      if (b != (8'hC0 ^ 8'(i * 3))) bad++;
    end
    check(bad == 0, "R5 data", bad, 0);
    clearDone();
  endtask

  task automatic test_id();
    logic [7:0] b;
    int base = rdCount;
    int bad = 0;
    for (int i = 0; i < ID_BYTES; i++) rdData[base + i] = 8'h20 + 8'(i);
    regWrite(2'd3, 16'h0010);
    waitDone("R6 done");
    check(rdCount - base == ID_BYTES, "R6 count", rdCount - base, ID_BYTES);
    for (int i = 0; i < ID_BYTES; i++) begin
      bufRead(i, b);
      if (b != 8'h20 + 8'(i)) bad++;
    end
    check(bad == 0, "R6 data", bad, 0);
    bufRead(ID_BYTES, b);
    check(b == (8'hC0 ^ 8'(ID_BYTES * 3)), "R6 rest untouched", b, 8'hC0 ^ 8'(ID_BYTES * 3));
    clearDone();
  endtask

  task automatic test_status();
    logic [7:0] b;
    int base = rdCount;
    regWrite(2'd2, 16'h0001);
    bufWrite(AREA + 1, 8'h5A);
    rdData[base] = 8'hE0;
    regWrite(2'd3, 16'h0020);
    waitDone("R7 done");
    check(rdCount - base == 1, "R7 count", rdCount - base, 1);
    bufRead(AREA, b);     check(b == 8'hE0, "R7 status byte", b, 8'hE0);
    bufRead(AREA + 1, b); check(b == 8'h5A, "R7 neighbour", b, 8'h5A);
    clearDone();
  endtask

  task automatic test_busy_launch();
    logic [15:0] v;
    int base = wrCount;
    int clePulses = 0;
    regWrite(2'd2, 16'h0000);
    regWrite(2'd3, 16'h0004);
    regWrite(2'd3, 16'h0001);
    regRead(2'd3, v);
    check(v[5:0] == 6'h04, "R9 running code", v[5:0], 6'h04);
    waitDone("R9 done");
    check(wrCount - base == AREA, "R9 count", wrCount - base, AREA);
    for (int i = base; i < wrCount; i++) if (wrCle[i]) clePulses++;
    check(clePulses == 0, "R9 no command latch", clePulses, 0);
    clearDone();
    repeat (30) @(negedge clk);
    check(wrCount - base == AREA, "R9 nothing queued", wrCount - base, AREA);
  endtask

  task automatic test_bad_launch();
    logic [15:0] v;
    int wb = wrCount;
    int rb = rdCount;
    regWrite(2'd3, 16'h0003);
    repeat (30) @(negedge clk);
    regRead(2'd3, v);
    check(v == 16'h0000, "R10 two bits", v, 0);
    regWrite(2'd3, 16'h0000);
    repeat (30) @(negedge clk);
    regRead(2'd3, v);
    check(v == 16'h0000, "R10 zero code", v, 0);
    check(wrCount == wb && rdCount == rb, "R10 no strobe", (wrCount - wb) + (rdCount - rb), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    test_reset();
    test_regs();
    test_cmd();
    test_addr();
    test_page_write(0);
    test_page_write(1);
    test_page_read();
    test_id();
    test_status();
    test_busy_launch();
    test_bad_launch();
    check(timingErr == 0, "R11 strobe timing", timingErr, 0);
    check(!(nandCle && nandAle), "R12 latch exclusive", {nandCle, nandAle}, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual 0x0 expected 0x1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule